// File: doc/BRIEF.md
# HyperBus Transaction Master

This block runs one HyperBus-style transaction at a time against an external NOR flash. A local requester supplies the direction, the address space (register or memory), the burst type, a byte address, a transfer size and, for writes, the payload. The block builds a 48-bit command-address word and sends it 16 bits per clock. For a read, it then waits a fixed latency. After that it moves 16-bit data beats, and each beat also carries 16 bits per clock. The transaction ends with a one-cycle done pulse. For a read, the captured data is valid on the output while done is high.

Double-data-rate transfer is shown at the port as two byte lanes per clock. The rise lane carries the byte sent on the rising edge and the fall lane carries the byte sent on the falling edge. A physical layer outside this block turns the lanes into pin toggles. Register-space payloads travel most significant byte first. Memory-space payloads travel least significant byte first. Transfers are 16, 32 or 64 bits wide.

Top module: `hbus_xact_master`

## Requirements
- R1: Command-address bit 47 is 1 for a read and 0 for a write.
- R2: Command-address bit 46 is 1 for register space and 0 for memory space.
- R3: Command-address bit 45 is 1 for a linear burst and 0 for a wrapped burst.
- R4: The word address is the byte address shifted right by one, so byte-address bit 0 is dropped. Word-address bits 31..3 go to command-address bits 44..16, bits 2..0 go to bits 2..0, and bits 15..3 are zero. The word is sent over three cycles, bits 47..32 first, with {dq_rise,dq_fall} carrying each 16-bit slice.
- R5: A read has exactly 14 latency cycles between the command-address and the first data beat, with dq_oe low. A write starts data directly after the command-address.
- R6: req_size 0, 1 and 2 give 1, 2 and 4 data beats (16, 32 and 64 bits), and size 3 is treated as 64 bits.
- R7: A beat on the bus is {dq_rise,dq_fall}. In register space, halfword h travels as {h[15:8],h[7:0]}. In memory space it travels as {h[7:0],h[15:8]}. This applies to both directions.
- R8: Beat k maps to data halfword k (bits 16k+15..16k) for 16- and 32-bit transfers. For 64-bit transfers it maps to halfword k XOR 2, so the first two beats carry bits 63..32.
- R9: cs_n goes low in the cycle after acceptance and stays low through the command, latency and data cycles. It rises in the cycle after the last beat, so a transfer holds cs_n low for 3 + latency + beats cycles.
- R10: A request is accepted only when busy is low. busy stays high from acceptance until done. done is a single-cycle pulse, and a request raised while busy is ignored.
- R11: After reset, cs_n is 1 and busy, done and dq_oe are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_read | input | 1 | 1 read, 0 write |
| req_reg | input | 1 | 1 register space, 0 memory space |
| req_linear | input | 1 | 1 linear burst, 0 wrapped |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | 0:16, 1:32, 2:64 bits |
| req_wdata | input | 64 | Write payload |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 64 | Read result, valid with done |
| cs_n | output | 1 | Chip select, active low |
| dq_oe | output | 1 | Drive enable for the data lanes |
| dq_rise | output | 8 | Byte for the rising edge |
| dq_fall | output | 8 | Byte for the falling edge |
| dq_in_rise | input | 8 | Byte captured on the rising edge |
| dq_in_fall | input | 8 | Byte captured on the falling edge |

## Verification
The in-line assertions check the following every cycle: busy follows an accepted request, the latched command stays stable while a transfer runs, and done is a lone pulse that comes just as cs_n rises. They also check that the bus is undriven during read latency and read data, and that the beat counter never passes the size. The bench scenarios are needed to show the values that travel: the command-address bits, the byte and halfword order in each space and size, the exact latency, and the read result. The bench also shows that a request raised during a transfer leaves it unchanged and starts nothing after it.

// File: rtl/hbus_xact_master.sv
module hbus_xact_master #(
  parameter int ADDR_W  = 32,
  parameter int LATENCY = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_read,
  input  logic              req_reg,
  input  logic              req_linear,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [63:0]       req_wdata,
  output logic              busy,
  output logic              done,
  output logic [63:0]       rdata,
  output logic              cs_n,
  output logic              dq_oe,
  output logic [7:0]        dq_rise,
  output logic [7:0]        dq_fall,
  input  logic [7:0]        dq_in_rise,
  input  logic [7:0]        dq_in_fall
);
  localparam int CNT_W = $clog2(LATENCY + 4) + 1;

  typedef enum logic [1:0] {S_IDLE, S_CA, S_LAT, S_DATA} state_t;

  state_t           state;
  logic [CNT_W-1:0] cnt;
  logic             rd_q, reg_q;
  logic [47:0]      ca_q;
  logic [63:0]      wdata_q;
  logic [2:0]       beats_q;
  logic [31:0]      wa;
  logic [1:0]       slot;
  logic [15:0]      tx_half, rx_half, ca_half;
  logic             accept;

  assign accept  = req_valid && (state == S_IDLE);
  assign wa      = 32'(req_addr >> 1);
  assign slot    = (beats_q == 3'd4) ? (cnt[1:0] ^ 2'd2) : cnt[1:0];
  assign tx_half = wdata_q[{slot, 4'd0} +: 16];
  assign rx_half = reg_q ? {dq_in_rise, dq_in_fall} : {dq_in_fall, dq_in_rise};
  assign ca_half = (cnt == CNT_W'(0)) ? ca_q[47:32] :
                   (cnt == CNT_W'(1)) ? ca_q[31:16] : ca_q[15:0];

  assign busy  = (state != S_IDLE);
  assign cs_n  = (state == S_IDLE);
  assign dq_oe = (state == S_CA) || (state == S_DATA && !rd_q);

  always_comb begin
    if (state == S_CA)
      {dq_rise, dq_fall} = ca_half;
    else if (state == S_DATA && !rd_q)
      {dq_rise, dq_fall} = reg_q ? tx_half : {tx_half[7:0], tx_half[15:8]};
    else
      {dq_rise, dq_fall} = 16'h0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      done    <= 1'b0;
      rdata   <= '0;
      rd_q    <= 1'b0;
      reg_q   <= 1'b0;
      ca_q    <= '0;
      wdata_q <= '0;
      beats_q <= 3'd1;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          rd_q    <= req_read;
          reg_q   <= req_reg;
          ca_q    <= {req_read, req_reg, req_linear, wa[31:3], 13'd0, wa[2:0]};
          wdata_q <= req_wdata;
          beats_q <= (req_size == 2'd0) ? 3'd1 : (req_size == 2'd1) ? 3'd2 : 3'd4;
          rdata   <= '0;
          cnt     <= '0;
          state   <= S_CA;
        end
        S_CA: if (cnt == CNT_W'(2)) begin
          cnt   <= '0;
          state <= rd_q ? S_LAT : S_DATA;
        end else cnt <= cnt + 1'b1;
        S_LAT: if (cnt == CNT_W'(LATENCY - 1)) begin
          cnt   <= '0;
          state <= S_DATA;
        end else cnt <= cnt + 1'b1;
        S_DATA: begin
          if (rd_q) rdata[{slot, 4'd0} +: 16] <= rx_half;
          if (cnt == CNT_W'(beats_q) - 1'b1) begin
            cnt   <= '0;
            done  <= 1'b1;
            state <= S_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> busy);
  assert_hold_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(ca_q) && $stable(wdata_q)));
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_cs_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && $past(!cs_n)));
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_n && !dq_oe));
  assert_read_undriven_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_q && state != S_CA) |-> !dq_oe);
  assert_beat_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DATA) |-> (cnt < CNT_W'(beats_q)));
endmodule

// File: tb/tb_hbus_xact_master.sv
`timescale 1ns/1ps
module tb_hbus_xact_master;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_read = 1'b0, req_reg = 1'b0, req_linear = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [63:0] req_wdata = '0;
  logic busy, done, cs_n, dq_oe;
  logic [63:0] rdata;
  logic [7:0] dq_rise, dq_fall;
  logic [7:0] dq_in_rise = '0, dq_in_fall = '0;

  int total = 0, bad = 0;
  bit finished = 0;

  hbus_xact_master dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_read(req_read),
    .req_reg(req_reg), .req_linear(req_linear), .req_addr(req_addr),
    .req_size(req_size), .req_wdata(req_wdata), .busy(busy), .done(done),
    .rdata(rdata), .cs_n(cs_n), .dq_oe(dq_oe), .dq_rise(dq_rise),
    .dq_fall(dq_fall), .dq_in_rise(dq_in_rise), .dq_in_fall(dq_in_fall));

  always #2.5 clk = ~clk;

  logic [47:0] got_ca;
  logic [63:0] got_w, got_rdata;
  int got_low, got_cycles, got_nw;
  logic got_done, got_busy;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int nbeats(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  function automatic int slot_of(input logic [1:0] sz, input int k);
    return (nbeats(sz) == 4) ? (k ^ 2) : k;
  endfunction

  function automatic logic [15:0] on_bus(input logic [15:0] h, input logic rg);
    return rg ? h : {h[7:0], h[15:8]};
  endfunction

  task automatic run(input logic rd, input logic rg, input logic ln, input logic [31:0] addr,
                     input logic [1:0] sz, input logic [63:0] wd, input logic [63:0] rb,
                     input bit poke);
    int idx, nr;
    @(negedge clk);
    req_valid = 1'b1; req_read = rd; req_reg = rg; req_linear = ln;
    req_addr = addr; req_size = sz; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    idx = 0; nr = 0; got_nw = 0; got_low = 0; got_ca = '0; got_w = '0;
    while (cs_n == 1'b0 && idx < 64) begin
      if (poke && idx == 1) begin
        req_valid = 1'b1; req_read = 1'b1; req_reg = ~rg; req_size = 2'd2;
      end
      if (poke && idx == 2) req_valid = 1'b0;
      if (idx < 3) got_ca[47-16*idx -: 16] = {dq_rise, dq_fall};
      else if (dq_oe) begin
        got_w[16*got_nw +: 16] = {dq_rise, dq_fall};
        got_nw++;
      end else if (idx >= 17) begin
        {dq_in_rise, dq_in_fall} = rb[16*nr +: 16];
        nr++;
      end else begin
        got_low++;
        {dq_in_rise, dq_in_fall} = 16'hBEEF;
      end
      idx++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    got_cycles = idx; got_done = done; got_busy = busy; got_rdata = rdata;
  endtask

  task automatic verify(input string nm, input logic rd, input logic rg, input logic ln,
                        input logic [31:0] addr, input logic [1:0] sz,
                        input logic [63:0] wd, input logic [63:0] rb);
    logic [31:0] wa;
    logic [63:0] expw, expr;
    logic [15:0] h;
    wa = {1'b0, addr[31:1]};
    chk({nm, " R1 ca47"}, 64'(got_ca[47]), 64'(rd));
    chk({nm, " R2 ca46"}, 64'(got_ca[46]), 64'(rg));
    chk({nm, " R3 ca45"}, 64'(got_ca[45]), 64'(ln));
    chk({nm, " R4 address"}, 64'(got_ca[44:0]), 64'({wa[31:3], 13'd0, wa[2:0]}));
    chk({nm, " R5 latency"}, 64'(got_low), rd ? 64'd14 : 64'd0);
    chk({nm, " R9 cs low cycles"}, 64'(got_cycles), 64'(3 + (rd ? 14 : 0) + nbeats(sz)));
    chk({nm, " R10 done/busy at end"}, {62'd0, got_done, got_busy}, 64'd2);
    expw = '0; expr = '0;
    for (int k = 0; k < nbeats(sz); k++) begin
      h = wd[16*slot_of(sz, k) +: 16];
      expw[16*k +: 16] = on_bus(h, rg);
      h = rb[16*k +: 16];
      expr[16*slot_of(sz, k) +: 16] = rg ? h : {h[7:0], h[15:8]};
    end
    if (rd) chk({nm, " R6 R7 R8 read data"}, got_rdata, expr);
    else begin
      chk({nm, " R6 beat count"}, 64'(got_nw), 64'(nbeats(sz)));
      chk({nm, " R7 R8 write beats"}, got_w, expw);
    end
  endtask

  task automatic t_reset;
    chk("R11 reset outputs", {60'd0, cs_n, busy, done, dq_oe}, 64'h8);
  endtask

  task automatic t_wr16_mem;
    run(0, 0, 0, 32'h0000_0AAA, 2'd0, 64'h0000_0000_0000_12AB, '0, 0);
    verify("wr16 mem", 0, 0, 0, 32'h0000_0AAA, 2'd0, 64'h12AB, '0);
  endtask

  task automatic t_wr32_reg;
    run(0, 1, 1, 32'h0012_3456, 2'd1, 64'h0000_0000_A1B2_C3D4, '0, 0);
    verify("wr32 reg", 0, 1, 1, 32'h0012_3456, 2'd1, 64'hA1B2_C3D4, '0);
  endtask

  task automatic t_wr64_mem;
    run(0, 0, 1, 32'hFFFF_FFF8, 2'd2, 64'h1111_2222_3333_4444, '0, 0);
    verify("wr64 mem", 0, 0, 1, 32'hFFFF_FFF8, 2'd2, 64'h1111_2222_3333_4444, '0);
  endtask

  task automatic t_rd16_reg;
    run(1, 1, 0, 32'h0000_004E, 2'd0, '0, 64'h0000_0000_0000_0022, 0);
    verify("rd16 reg", 1, 1, 0, 32'h0000_004E, 2'd0, '0, 64'h22);
  endtask

  task automatic t_rd32_mem;
    run(1, 0, 1, 32'h0400_0010, 2'd1, '0, 64'h0000_0000_5566_7788, 0);
    verify("rd32 mem", 1, 0, 1, 32'h0400_0010, 2'd1, '0, 64'h5566_7788);
  endtask

  task automatic t_rd64_reg;
    run(1, 1, 1, 32'h0000_0020, 2'd2, '0, 64'hDD04_CC03_BB02_AA01, 0);
    verify("rd64 reg", 1, 1, 1, 32'h0000_0020, 2'd2, '0, 64'hDD04_CC03_BB02_AA01);
  endtask

  task automatic t_rd64_mem_odd;
    run(1, 0, 0, 32'h00AB_CDEF, 2'd3, '0, 64'h0F0E_0D0C_0B0A_0908, 0);
    verify("rd64 mem odd addr", 1, 0, 0, 32'h00AB_CDEF, 2'd3, '0, 64'h0F0E_0D0C_0B0A_0908);
  endtask

  task automatic t_busy_ignore;
    int lowcs;
    run(0, 0, 0, 32'h0000_0100, 2'd0, 64'h0000_0000_0000_5A5A, '0, 1);
    verify("busy poke", 0, 0, 0, 32'h0000_0100, 2'd0, 64'h5A5A, '0);
    lowcs = 0;
    for (int i = 0; i < 4; i++) begin
      if (cs_n == 1'b0) lowcs++;
      @(negedge clk);
    end
    chk("R10 request during busy ignored", 64'(lowcs), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_wr16_mem();
    t_wr32_reg();
    t_wr64_mem();
    t_rd16_reg();
    t_rd32_mem();
    t_rd64_reg();
    t_rd64_mem_odd();
    t_busy_ignore();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule